// File: doc/BRIEF.md
# Tri-Statable Vector Pattern Output Bank

This block holds stimulus patterns for a group of tester output channels and plays them back onto those channels. It is made of `NUM_BANKS` identical banks. Each bank has a pattern memory of `2**ADDR_W` bytes (`ADDR_W = 13` gives 8K entries; the default is kept small) feeding an 8-bit output register. Each stored byte controls four channels: for each line it carries a drive level and an enable. Ten banks give forty channels. The pad buffers sit outside the block, so every channel comes out as a level and enable pair.

Software fills the memories through a host write port. It can select any set of banks in the same cycle. Writes are refused while playback is running. During playback an external sequencer presents an address. The memory reads it on the next clock. A latch strobe one clock later copies that byte into the output register, so a new vector can appear on every cycle.

An active-low clear input empties the output register at once, without waiting for the clock. This tri-states every channel. Reset leaves the outputs in the same safe state.

Top module: `vecpat_out_bank`

## Requirements
- R1: While `rst_n` is low, and after its release until the first capture, every bit of `ch_oe` and `ch_lvl` is 0.
- R2: When `host_wr_en` is 1, `host_wr_sel[b]` is 1 and `play_en` is 0 at a clock edge, bank b stores `host_wr_data` at `host_wr_addr`.
- R3: A host write presented while `play_en` is 1 changes no memory location in any bank.
- R4: A bank whose `host_wr_sel` bit is 0 keeps its contents during a host write to other banks.
- R5: With `play_en` at 1, the address on `play_addr` at edge k is read. If `lat_stb` and `play_en` are both 1 at edge k+1, that byte reaches the outputs after edge k+1. Back-to-back addresses give one vector per clock.
- R6: Channel 4*b+j belongs to bank b, line j (j = 0..3). The level of line j sits in byte bit j and its enable in byte bit 4+j, where 1 means driven.
- R7: A channel whose enable bit is 0 shows `ch_oe` = 0 and `ch_lvl` = 0, whatever its level bit holds.
- R8: `tri_n` low clears the output register immediately, with no clock needed. The register stays cleared while `tri_n` is low, even if `lat_stb` is high.
- R9: With `lat_stb` at 0, the outputs hold their value, whatever `play_addr` does.
- R10: With `play_en` at 0, `lat_stb` has no effect and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tri_n | input | 1 | Asynchronous active-low output clear (tri-states all channels) |
| host_wr_en | input | 1 | Host write request |
| host_wr_sel | input | NUM_BANKS | Per-bank write select, any number of bits may be set |
| host_wr_addr | input | ADDR_W | Host write address |
| host_wr_data | input | 8 | Byte to store: levels in [3:0], enables in [7:4] |
| play_en | input | 1 | Playback active; enables reads and latching, blocks host writes |
| play_addr | input | ADDR_W | Current playback address, read at the next edge |
| lat_stb | input | 1 | Latch strobe: copies the last read byte into the output register |
| ch_lvl | output | 4*NUM_BANKS | Drive level per channel, 0 when not driven |
| ch_oe | output | 4*NUM_BANKS | Output enable per channel, 0 means high impedance |

## Verification
Two pairs of functions can meet in one cycle here. The first pair is a host write and a playback read of the same address. The bench drives a write with all banks selected on the edge that reads that location. It then reads the location again later. Both captures must show the old byte, so the blocked write cannot hide behind read timing.

The second pair is the clear input and the latch strobe. The bench holds `tri_n` low while `lat_stb` and `play_en` are high for several edges. It checks between edges that every enable stays at 0. When `tri_n` is released, the very next strobe must restore the vector at the held address.

// File: rtl/vecpat_pkg.sv
package vecpat_pkg;

    localparam int unsigned LINES_PER_BANK = 4;
    localparam int unsigned VBYTE_W        = 2 * LINES_PER_BANK;

    // Stored byte: enables in the upper half, levels in the lower half.
    typedef struct packed {
        logic [LINES_PER_BANK-1:0] en;
        logic [LINES_PER_BANK-1:0] lvl;
    } vec_byte_t;

endpackage

// File: rtl/vecpat_bank_mem.sv
module vecpat_bank_mem
    import vecpat_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  vec_byte_t         wr_data_i,
    input  logic              play_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output vec_byte_t         rd_data_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        vec_byte_t rd;
    } mem_state_t;

    vec_byte_t  mem_q [DEPTH];
    mem_state_t st_d, st_q;
    logic       wr_go_d;

    always_comb begin
        st_d    = st_q;
        wr_go_d = wr_en_i && wr_sel_i && !play_i;
        if (play_i) begin
            st_d.rd = mem_q[rd_addr_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go_d) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = st_q.rd;

    // R2: an accepted write lands at its address
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i && !play_i) |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));

    // R3: nothing is written while playback runs
    assert_play_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        play_i |=> (mem_q[$past(wr_addr_i)] == $past(mem_q[wr_addr_i])));

endmodule

// File: rtl/vecpat_out_latch.sv
module vecpat_out_latch
    import vecpat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tri_n,
    input  logic      cap_i,
    input  vec_byte_t din_i,
    output vec_byte_t q_o
);

    typedef struct packed {
        vec_byte_t val;
    } lat_state_t;

    lat_state_t st_d, st_q;
    logic       clr_n;

    assign clr_n = rst_n && tri_n;

    always_comb begin
        st_d = st_q;
        if (cap_i) begin
            st_d.val = din_i;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.val;

    // R8: a low clear input leaves the register empty
    assert_clear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tri_n |-> (q_o == '0));

    // R5: a strobe copies the read byte
    assert_capture_R5: assert property (@(posedge clk) disable iff (!clr_n)
        cap_i |=> (q_o == $past(din_i)));

    // R9: no strobe, no change
    assert_hold_R9: assert property (@(posedge clk) disable iff (!clr_n)
        !cap_i |=> $stable(q_o));

endmodule

// File: rtl/vecpat_line_map.sv
module vecpat_line_map
    import vecpat_pkg::*;
(
    input  vec_byte_t                 byte_i,
    output logic [LINES_PER_BANK-1:0] lvl_o,
    output logic [LINES_PER_BANK-1:0] oe_o
);

    for (genvar j = 0; j < LINES_PER_BANK; j++) begin : g_line
        always_comb begin
            oe_o[j]  = byte_i.en[j];
            lvl_o[j] = byte_i.en[j] ? byte_i.lvl[j] : 1'b0;
        end
    end

endmodule

// File: rtl/vecpat_out_bank.sv
module vecpat_out_bank
    import vecpat_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 10,
    parameter int unsigned ADDR_W    = 7,
    localparam int unsigned NCH      = NUM_BANKS * LINES_PER_BANK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tri_n,
    input  logic                 host_wr_en,
    input  logic [NUM_BANKS-1:0] host_wr_sel,
    input  logic [ADDR_W-1:0]    host_wr_addr,
    input  logic [VBYTE_W-1:0]   host_wr_data,
    input  logic                 play_en,
    input  logic [ADDR_W-1:0]    play_addr,
    input  logic                 lat_stb,
    output logic [NCH-1:0]       ch_lvl,
    output logic [NCH-1:0]       ch_oe
);

    logic cap_d;

    always_comb begin
        cap_d = lat_stb && play_en;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vec_byte_t rd_byte;
        vec_byte_t out_byte;

        vecpat_bank_mem #(
            .ADDR_W (ADDR_W)
        ) mem_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (host_wr_en),
            .wr_sel_i  (host_wr_sel[b]),
            .wr_addr_i (host_wr_addr),
            .wr_data_i (vec_byte_t'(host_wr_data)),
            .play_i    (play_en),
            .rd_addr_i (play_addr),
            .rd_data_o (rd_byte)
        );

        vecpat_out_latch lat_i (
            .clk   (clk),
            .rst_n (rst_n),
            .tri_n (tri_n),
            .cap_i (cap_d),
            .din_i (rd_byte),
            .q_o   (out_byte)
        );

        vecpat_line_map map_i (
            .byte_i (out_byte),
            .lvl_o  (ch_lvl[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .oe_o   (ch_oe[b*LINES_PER_BANK +: LINES_PER_BANK])
        );
    end

    // R7: an undriven channel never shows a high level
    assert_lvl_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_lvl & ~ch_oe) == '0));

    // R10: strobe without playback leaves the channels alone
    assert_idle_strobe_R10: assert property (@(posedge clk) disable iff (!(rst_n && tri_n))
        (!play_en && lat_stb) |=> ($stable(ch_oe) && $stable(ch_lvl)));

endmodule

// File: tb/vecpat_out_bank_tb.sv
module vecpat_out_bank_tb_top;

    localparam int NB  = 10;
    localparam int AW  = 7;
    localparam int NCH = NB * 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tri_n = 1'b1;
    logic            host_wr_en = 1'b0;
    logic [NB-1:0]   host_wr_sel = '0;
    logic [AW-1:0]   host_wr_addr = '0;
    logic [7:0]      host_wr_data = '0;
    logic            play_en = 1'b0;
    logic [AW-1:0]   play_addr = '0;
    logic            lat_stb = 1'b0;
    logic [NCH-1:0]  ch_lvl;
    logic [NCH-1:0]  ch_oe;

    always #2 clk = ~clk;

    vecpat_out_bank #(.NUM_BANKS(NB), .ADDR_W(AW)) dut_i (
        .clk (clk), .rst_n (rst_n), .tri_n (tri_n),
        .host_wr_en (host_wr_en), .host_wr_sel (host_wr_sel),
        .host_wr_addr (host_wr_addr), .host_wr_data (host_wr_data),
        .play_en (play_en), .play_addr (play_addr), .lat_stb (lat_stb),
        .ch_lvl (ch_lvl), .ch_oe (ch_oe)
    );

    typedef struct {
        int             due;
        logic [NCH-1:0] lvl;
        logic [NCH-1:0] oe;
        string          tag;
    } exp_t;

    exp_t       sbq[$];
    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 0;
    logic [7:0] model [NB][1<<AW];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk_out(input logic [NCH-1:0] el, input logic [NCH-1:0] eo, input string tag);
        n_cmp++;
        if (ch_lvl !== el || ch_oe !== eo) begin
            n_bad++;
            $display("FAIL %s: lvl=%h oe=%h expected lvl=%h oe=%h", tag, ch_lvl, ch_oe, el, eo);
        end
    endtask

    // monitor: pops expected items when their cycle comes
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            if (e.due != cyc) begin
                n_cmp++;
                n_bad++;
                $display("FAIL %s: missed at cycle %0d expected cycle %0d", e.tag, cyc, e.due);
            end else begin
                chk_out(e.lvl, e.oe, e.tag);
            end
        end
    end

    function automatic void exp_of(input int a, output logic [NCH-1:0] el, output logic [NCH-1:0] eo);
        el = '0;
        eo = '0;
        for (int b = 0; b < NB; b++) begin
            for (int j = 0; j < 4; j++) begin
                eo[4*b+j] = model[b][a][4+j];
                el[4*b+j] = model[b][a][4+j] & model[b][a][j];
            end
        end
    endfunction

    task automatic push(input int due, input logic [NCH-1:0] el, input logic [NCH-1:0] eo, input string tag);
        exp_t e;
        e.due = due; e.lvl = el; e.oe = eo; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic host_write(input logic [NB-1:0] sel, input int a, input logic [7:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_sel = sel; host_wr_addr = AW'(a); host_wr_data = d;
        if (!play_en) begin
            for (int b = 0; b < NB; b++) if (sel[b]) model[b][a] = d;
        end
        @(negedge clk);
        host_wr_en = 1'b0; host_wr_sel = '0;
    endtask

    // pipelined playback: one address per clock, one vector per clock (R5)
    task automatic stream(input int a0, input int n, input string tag);
        logic [NCH-1:0] el, eo;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            play_en = 1'b1;
            lat_stb = (i > 0);
            if (i < n) begin
                play_addr = AW'(a0 + i);
                exp_of(a0 + i, el, eo);
                push(cyc + 2, el, eo, tag);
            end
        end
        @(negedge clk);
        lat_stb = 1'b0;
    endtask

    task automatic play_one(input int a, input logic [NCH-1:0] el, input logic [NCH-1:0] eo, input string tag);
        @(negedge clk);
        play_en = 1'b1; play_addr = AW'(a); lat_stb = 1'b0;
        push(cyc + 2, el, eo, tag);
        @(negedge clk);
        lat_stb = 1'b1;
        @(negedge clk);
        lat_stb = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] el, eo, hl, ho;
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < (1 << AW); a++) model[b][a] = 8'h00;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk_out('0, '0, "R1 during reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_out('0, '0, "R1 after reset");

        // R2 fill: one-hot selects, mixed level/enable patterns
        for (int a = 0; a < (1 << AW); a++) host_write({NB{1'b1}}, a, 8'h00);
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < 16; a++)
                host_write(NB'(1) << b, a, 8'((b * 37 + a * 11 + 5) & 8'hFF));

        // R5, R6, R7, R2: back-to-back playback of the stored patterns
        stream(0, 16, "R2/R5/R7 stream");
        @(negedge clk); play_en = 1'b0;

        // R6: explicit channel mapping, bank 3 byte AF -> lines 1 and 3 driven high
        host_write(NB'(1) << 3, 20, 8'hAF);
        el = (NCH'(1) << 13) | (NCH'(1) << 15);
        play_one(20, el, el, "R6/R7 bank3 lines");
        @(negedge clk); play_en = 1'b0;

        // R3: write attempted on the same edge that reads that address
        exp_of(5, el, eo);
        @(negedge clk);
        play_en = 1'b1; play_addr = AW'(5); lat_stb = 1'b0;
        host_wr_en = 1'b1; host_wr_sel = {NB{1'b1}}; host_wr_addr = AW'(5); host_wr_data = 8'hFF;
        push(cyc + 2, el, eo, "R3 same-cycle read");
        @(negedge clk);
        host_wr_en = 1'b0; host_wr_sel = '0; lat_stb = 1'b1;
        @(negedge clk);
        lat_stb = 1'b0;
        play_one(9, 'x, 'x, "dummy");
        sbq.delete(sbq.size() - 1);
        play_one(5, el, eo, "R3 later read");

        // R4: write only bank 0 at address 6
        @(negedge clk); play_en = 1'b0;
        host_write(NB'(1), 6, 8'hF3);
        exp_of(6, el, eo);
        play_one(6, el, eo, "R4 unselected banks unchanged");

        // R9: strobe low, address moving -> hold
        stream(10, 3, "R5 stream 2");
        exp_of(12, hl, ho);
        @(negedge clk);
        lat_stb = 1'b0;
        for (int i = 0; i < 3; i++) begin
            play_addr = AW'(i);
            push(cyc + 1, hl, ho, "R9 hold");
            @(negedge clk);
        end

        // R10: strobe without playback -> hold
        play_en = 1'b0; lat_stb = 1'b1; play_addr = AW'(3);
        for (int i = 0; i < 3; i++) begin
            push(cyc + 1, hl, ho, "R10 idle strobe");
            @(negedge clk);
        end
        lat_stb = 1'b0;

        // R8: asynchronous clear, then clear colliding with strobe
        play_one(7, 'x, 'x, "dummy");
        sbq.delete(sbq.size() - 1);
        @(negedge clk);
        #1 tri_n = 1'b0;
        #0.5 chk_out('0, '0, "R8 immediate clear");
        @(negedge clk);
        play_en = 1'b1; play_addr = AW'(8); lat_stb = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_out('0, '0, "R8 clear beats strobe");
        end
        tri_n = 1'b1;
        exp_of(8, el, eo);
        push(cyc + 1, el, eo, "R8 release then capture");
        @(negedge clk);
        lat_stb = 1'b0; play_en = 1'b0;

        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: %0d items left expected 0", sbq.size());
        end
        done = 1;
        report();
        $finish;
    end

endmodule